// File: doc/BRIEF.md
# Virtual-8086 Interrupt Entry Sequencer

This block carries out the hardware side of entering a protected-mode handler when an interrupt or exception arrives while the core runs 8086 code in virtual-8086 mode. It receives a gate descriptor that has already been fetched, reduced to its type code, target selector, target offset, and the conforming bit and privilege level of the target code segment. It also receives the live register values to be saved and the level-0 stack pointer. On a one-cycle `start` pulse it validates the gate. It then either signals a fault, requests a task switch, or writes nine 32-bit words onto the level-0 stack.

After the last word is accepted, it commits the handler context in one step. That context is CS:EIP from the gate, SS:ESP at the new stack top, privilege level 0, 32-bit protected mode, adjusted flags, and the four data segment registers zeroed. Until that commit, the committed outputs keep their previous values. A rejected entry never changes them and never writes memory.

Top module: `v86_irq_entry`

## Requirements
- R1: The type code `gate_type` is decoded as 4'hE for a 32-bit interrupt gate, 4'hF for a 32-bit trap gate and 4'h5 for a task gate. Any other code pulses `fault` for one cycle, in the cycle after `start` is sampled. At most one of `done`, `fault` and `task_sw_req` is high in any cycle.
- R2: For an interrupt or trap gate whose target is conforming (`tgt_conf`=1) or has `tgt_dpl` other than 0, `fault` pulses one cycle after `start` and no memory write is issued. Every fault drives `fault_vec` to 13.
- R3: A task gate pulses `task_sw_req` one cycle after `start`, with `tsw_vec` equal to the `vector` given at start, and issues no memory write.
- R4: A valid interrupt or trap gate causes exactly nine writes.
  - Order: GS, FS, DS, ES, SS, ESP, EFLAGS, CS, EIP.
  - Data: 32 bits, with 16-bit selectors zero-extended.
  - Segment: `mem_wr_seg` equals `stk0_ss`.
  - Offsets: `stk0_esp`-4, -8, and so on down to -36.
- R5: A write is held, with address and data unchanged, until `mem_wr_ready` is high at a rising edge.
- R6: `done` pulses in the cycle after the ninth write is accepted. At that point:
  - `out_cs` = `gate_sel` and `out_eip` = `gate_off`.
  - `out_ss` = `stk0_ss` and `out_esp` = `stk0_esp`-36.
  - `out_cpl` = 0 and `out_pm32` = 1.
- R7: After `done`, `out_ds`, `out_es`, `out_fs` and `out_gs` are all zero.
- R8: The pushed EFLAGS word is `cur_eflags` unchanged. `out_eflags` is `cur_eflags` with VM (bit 17) and TF (bit 8) cleared, and with IF (bit 9) also cleared only for an interrupt gate.
- R9: A fault or task-switch request leaves every `out_*` port unchanged, and no `out_*` port changes in a cycle without `done`.
- R10: `start` is ignored while a push sequence is in progress.
- R11: After reset:
  - `done`, `fault`, `task_sw_req` and `mem_wr_valid` are low.
  - `out_cpl` is 3 and `out_pm32` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an entry (sampled when idle) |
| vector | input | 8 | Interrupt or exception vector |
| gate_type | input | 4 | Gate descriptor type code |
| gate_sel | input | 16 | Gate target code selector |
| gate_off | input | 32 | Gate target offset |
| tgt_conf | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Target code segment privilege level |
| cur_eip | input | 32 | Interrupted EIP |
| cur_cs | input | 16 | Interrupted CS |
| cur_eflags | input | 32 | Interrupted EFLAGS |
| cur_esp | input | 32 | Interrupted ESP |
| cur_ss | input | 16 | Interrupted SS |
| cur_es | input | 16 | Interrupted ES |
| cur_ds | input | 16 | Interrupted DS |
| cur_fs | input | 16 | Interrupted FS |
| cur_gs | input | 16 | Interrupted GS |
| stk0_ss | input | 16 | Level-0 stack selector |
| stk0_esp | input | 32 | Level-0 stack pointer |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_seg | output | 16 | Write segment selector |
| mem_wr_addr | output | 32 | Write offset |
| mem_wr_data | output | 32 | Write data |
| done | output | 1 | Entry complete pulse |
| fault | output | 1 | Entry rejected pulse |
| fault_vec | output | 8 | Fault vector (13) |
| task_sw_req | output | 1 | Task-gate switch request pulse |
| tsw_vec | output | 8 | Vector for the task switch |
| out_cpl | output | 2 | Committed privilege level |
| out_pm32 | output | 1 | Committed mode, 1 = 32-bit protected |
| out_cs | output | 16 | Committed CS |
| out_eip | output | 32 | Committed EIP |
| out_eflags | output | 32 | Committed EFLAGS |
| out_ss | output | 16 | Committed SS |
| out_esp | output | 32 | Committed ESP |
| out_ds | output | 16 | Committed DS |
| out_es | output | 16 | Committed ES |
| out_fs | output | 16 | Committed FS |
| out_gs | output | 16 | Committed GS |

## Verification
Each kind of internal error shows at the ports within the entry that causes it:

- A wrong push index appears at once as a misordered or miscounted write on the memory port.
- A wrong stack-pointer register gives an offset that breaks the 4-byte step on the very next accepted beat.
- A wrong gate decode shows one cycle after `start`, as the wrong event pulse or as a write where none may occur.
- A wrong commit shows in the `done` cycle, in `out_*` values that do not match the gate, the level-0 stack and the flag rules.

Sweeping every type code against every target attribute, with and without write stalls, reaches each of these paths.

// File: rtl/v86e_pkg.sv
package v86e_pkg;
  localparam logic [3:0] GT_TASK = 4'h5;
  localparam logic [3:0] GT_INTR = 4'hE;
  localparam logic [3:0] GT_TRAP = 4'hF;
  localparam int unsigned GP_VEC  = 13;
  localparam int unsigned FL_TF   = 8;
  localparam int unsigned FL_IF   = 9;
  localparam int unsigned FL_VM   = 17;
  typedef enum logic {ST_IDLE = 1'b0, ST_PUSH = 1'b1} seq_st_t;
endpackage

// File: rtl/v86e_gate_chk.sv
module v86e_gate_chk
  import v86e_pkg::*;
(
  input  logic [3:0] gate_type,
  input  logic       tgt_conf,
  input  logic [1:0] tgt_dpl,
  output logic       is_task,
  output logic       is_intr,
  output logic       go_push,
  output logic       reject
);
  logic is_gate32;
  always_comb begin
    is_task   = (gate_type == GT_TASK);
    is_intr   = (gate_type == GT_INTR);
    is_gate32 = is_intr || (gate_type == GT_TRAP);
    go_push   = is_gate32 && !tgt_conf && (tgt_dpl == 2'd0);
    reject    = !is_task && !go_push;
  end
endmodule

// File: rtl/v86e_push_sel.sv
module v86e_push_sel #(
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] s_gs,
  input  logic [SW-1:0] s_fs,
  input  logic [SW-1:0] s_ds,
  input  logic [SW-1:0] s_es,
  input  logic [SW-1:0] s_ss,
  input  logic [DW-1:0] s_esp,
  input  logic [DW-1:0] s_flags,
  input  logic [SW-1:0] s_cs,
  input  logic [DW-1:0] s_eip,
  output logic [DW-1:0] word
);
  localparam int PADW = DW - SW;
  always_comb begin
    case (idx)
      IW'(0):  word = {{PADW{1'b0}}, s_gs};
      IW'(1):  word = {{PADW{1'b0}}, s_fs};
      IW'(2):  word = {{PADW{1'b0}}, s_ds};
      IW'(3):  word = {{PADW{1'b0}}, s_es};
      IW'(4):  word = {{PADW{1'b0}}, s_ss};
      IW'(5):  word = s_esp;
      IW'(6):  word = s_flags;
      IW'(7):  word = {{PADW{1'b0}}, s_cs};
      default: word = s_eip;
    endcase
  end
endmodule

// File: rtl/v86e_flag_upd.sv
module v86e_flag_upd
  import v86e_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] flags_in,
  input  logic          intr_gate,
  output logic [DW-1:0] flags_out
);
  always_comb begin
    flags_out        = flags_in;
    flags_out[FL_VM] = 1'b0;
    flags_out[FL_TF] = 1'b0;
    if (intr_gate) flags_out[FL_IF] = 1'b0;
  end
endmodule

// File: rtl/v86_irq_entry.sv
module v86_irq_entry
  import v86e_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] vector,
  input  logic [3:0]    gate_type,
  input  logic [SW-1:0] gate_sel,
  input  logic [DW-1:0] gate_off,
  input  logic          tgt_conf,
  input  logic [1:0]    tgt_dpl,
  input  logic [DW-1:0] cur_eip,
  input  logic [SW-1:0] cur_cs,
  input  logic [DW-1:0] cur_eflags,
  input  logic [DW-1:0] cur_esp,
  input  logic [SW-1:0] cur_ss,
  input  logic [SW-1:0] cur_es,
  input  logic [SW-1:0] cur_ds,
  input  logic [SW-1:0] cur_fs,
  input  logic [SW-1:0] cur_gs,
  input  logic [SW-1:0] stk0_ss,
  input  logic [DW-1:0] stk0_esp,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [SW-1:0] mem_wr_seg,
  output logic [DW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          done,
  output logic          fault,
  output logic [VW-1:0] fault_vec,
  output logic          task_sw_req,
  output logic [VW-1:0] tsw_vec,
  output logic [1:0]    out_cpl,
  output logic          out_pm32,
  output logic [SW-1:0] out_cs,
  output logic [DW-1:0] out_eip,
  output logic [DW-1:0] out_eflags,
  output logic [SW-1:0] out_ss,
  output logic [DW-1:0] out_esp,
  output logic [SW-1:0] out_ds,
  output logic [SW-1:0] out_es,
  output logic [SW-1:0] out_fs,
  output logic [SW-1:0] out_gs
);
  localparam int NPUSH = 9;
  localparam int IW    = $clog2(NPUSH + 1);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  seq_st_t st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] esp_q, esp_d;
  logic [SW-1:0] c_gs, c_fs, c_ds, c_es, c_ss, c_cs, c_gsel, c_ss0;
  logic [DW-1:0] c_esp, c_flags, c_eip, c_goff;
  logic          c_intr;
  logic is_task, is_intr, go_push, reject;
  logic cap_en, beat, last_beat;
  logic [DW-1:0] push_word, new_flags;

  v86e_gate_chk u_chk_gate (
    .gate_type(gate_type), .tgt_conf(tgt_conf), .tgt_dpl(tgt_dpl),
    .is_task(is_task), .is_intr(is_intr), .go_push(go_push), .reject(reject)
  );

  v86e_push_sel #(.DW(DW), .SW(SW), .IW(IW)) u_sel (
    .idx(idx_q), .s_gs(c_gs), .s_fs(c_fs), .s_ds(c_ds), .s_es(c_es),
    .s_ss(c_ss), .s_esp(c_esp), .s_flags(c_flags), .s_cs(c_cs),
    .s_eip(c_eip), .word(push_word)
  );

  v86e_flag_upd #(.DW(DW)) u_flags (
    .flags_in(c_flags), .intr_gate(c_intr), .flags_out(new_flags)
  );

  assign cap_en    = (st_q == ST_IDLE) && start;
  assign beat      = (st_q == ST_PUSH) && mem_wr_ready;
  assign last_beat = beat && (idx_q == IW'(NPUSH - 1));

  assign mem_wr_valid = (st_q == ST_PUSH);
  assign mem_wr_seg   = c_ss0;
  assign mem_wr_addr  = esp_q;
  assign mem_wr_data  = push_word;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    esp_d = esp_q;
    if (cap_en && go_push) begin
      st_d  = ST_PUSH;
      idx_d = '0;
      esp_d = stk0_esp - STEP;
    end else if (beat) begin
      idx_d = idx_q + IW'(1);
      esp_d = esp_q - STEP;
      if (last_beat) st_d = ST_IDLE;
    end
  end

  // sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      esp_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      esp_q <= esp_d;
    end
  end

  // capture of entry context, enabled on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_gs, c_fs, c_ds, c_es, c_ss, c_cs, c_gsel, c_ss0} <= '0;
      {c_esp, c_flags, c_eip, c_goff} <= '0;
      c_intr <= 1'b0;
    end else if (cap_en) begin
      c_gs <= cur_gs;  c_fs <= cur_fs;  c_ds <= cur_ds;  c_es <= cur_es;
      c_ss <= cur_ss;  c_cs <= cur_cs;  c_esp <= cur_esp;
      c_flags <= cur_eflags;  c_eip <= cur_eip;
      c_gsel <= gate_sel;  c_goff <= gate_off;  c_ss0 <= stk0_ss;
      c_intr <= is_intr;
    end
  end

  // event pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      task_sw_req <= 1'b0;
      fault_vec   <= '0;
      tsw_vec     <= '0;
    end else begin
      done        <= last_beat;
      fault       <= cap_en && reject;
      task_sw_req <= cap_en && is_task;
      if (cap_en && reject) fault_vec <= VW'(GP_VEC);
      if (cap_en && is_task) tsw_vec <= vector;
    end
  end

  // committed context, enabled only by the final accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cpl    <= 2'd3;
      out_pm32   <= 1'b0;
      out_cs     <= '0;
      out_eip    <= '0;
      out_eflags <= '0;
      out_ss     <= '0;
      out_esp    <= '0;
      out_ds     <= '0;
      out_es     <= '0;
      out_fs     <= '0;
      out_gs     <= '0;
    end else if (last_beat) begin
      out_cpl    <= 2'd0;
      out_pm32   <= 1'b1;
      out_cs     <= c_gsel;
      out_eip    <= c_goff;
      out_eflags <= new_flags;
      out_ss     <= c_ss0;
      out_esp    <= esp_q;
      out_ds     <= '0;
      out_es     <= '0;
      out_fs     <= '0;
      out_gs     <= '0;
    end
  end
endmodule

// File: rtl/v86e_sva.sv
module v86e_sva #(
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          fault,
  input logic          task_sw_req,
  input logic [VW-1:0] fault_vec,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [DW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic [1:0]    out_cpl,
  input logic          out_pm32,
  input logic [SW-1:0] out_cs,
  input logic [DW-1:0] out_eip,
  input logic [DW-1:0] out_eflags
);
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, task_sw_req})); // R1
  AST_FAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_vec == VW'(13)); // R2
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_wr_valid); // R2
  AST_TASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw_req |-> !mem_wr_valid); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready) |=>
      (!mem_wr_valid || mem_wr_addr == $past(mem_wr_addr) - DW'(4))); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R5
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr_valid && mem_wr_ready)); // R6
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_eflags[17] && !out_eflags[8] && out_cpl == 2'd0 && out_pm32)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_eip) && $stable(out_cs) && $stable(out_cpl))); // R9
endmodule

bind v86_irq_entry v86e_sva #(.DW(DW), .SW(SW), .VW(VW)) u_sva (
  .clk(clk), .rst_n(rst_n), .done(done), .fault(fault),
  .task_sw_req(task_sw_req), .fault_vec(fault_vec),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .out_cpl(out_cpl), .out_pm32(out_pm32), .out_cs(out_cs),
  .out_eip(out_eip), .out_eflags(out_eflags)
);

// File: tb/v86_irq_entry_tb.sv
module v86_irq_entry_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, tgt_conf = 0, mem_wr_ready = 1;
  logic [7:0] vector = 0;
  logic [3:0] gate_type = 0;
  logic [1:0] tgt_dpl = 0;
  logic [15:0] gate_sel = 0, cur_cs = 0, cur_ss = 0, cur_es = 0, cur_ds = 0;
  logic [15:0] cur_fs = 0, cur_gs = 0, stk0_ss = 0;
  logic [31:0] gate_off = 0, cur_eip = 0, cur_eflags = 0, cur_esp = 0, stk0_esp = 0;
  logic mem_wr_valid, done, fault, task_sw_req, out_pm32;
  logic [15:0] mem_wr_seg, out_cs, out_ss, out_ds, out_es, out_fs, out_gs;
  logic [31:0] mem_wr_addr, mem_wr_data, out_eip, out_eflags, out_esp;
  logic [7:0] fault_vec, tsw_vec;
  logic [1:0] out_cpl;

  v86_irq_entry u_dut (.*);

  int n_run = 0, n_fail = 0, wcnt = 0, cyc = 0;
  bit stall_en = 0;
  logic [31:0] r_addr [0:15];
  logic [31:0] r_data [0:15];
  logic [15:0] r_seg  [0:15];

  always @(negedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      if (wcnt < 16) begin
        r_addr[wcnt] = mem_wr_addr; r_data[wcnt] = mem_wr_data; r_seg[wcnt] = mem_wr_seg;
      end
      wcnt = wcnt + 1;
    end
    cyc = cyc + 1;
    mem_wr_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  task automatic run_case(input int i);
    logic [31:0] exp_w [0:8];
    logic [31:0] fl, efl;
    logic [15:0] p_cs; logic [31:0] p_eip, p_esp, p_fl; logic [1:0] p_cpl; logic p_pm;
    int kind; int ev; int seen_ev;
    gate_type = i[3:0]; tgt_conf = i[4]; tgt_dpl = i[6:5];
    kind = (gate_type == 4'h5) ? 1 :
           ((gate_type == 4'hE || gate_type == 4'hF) && !tgt_conf && tgt_dpl == 0) ? 2 : 0;
    vector = 8'(i + 32);
    gate_sel = 16'h0100 + 16'(i); gate_off = 32'h4000_0000 + 32'(i * 17);
    cur_gs = 16'h1000 + 16'(i); cur_fs = 16'h2000 + 16'(i * 3);
    cur_ds = 16'h3000 + 16'(i * 5); cur_es = 16'h4000 + 16'(i * 7);
    cur_ss = 16'h5000 + 16'(i); cur_esp = 32'h0000_F000 - 32'(i * 8);
    fl = 32'h0002_0302 | (32'(i) << 24); cur_eflags = fl;
    cur_cs = 16'h6000 + 16'(i); cur_eip = 32'h0001_0000 + 32'(i * 9);
    stk0_ss = 16'h0010 + 16'(i); stk0_esp = 32'h0000_8000 + 32'(i * 64);
    stall_en = i[0] ^ i[3];
    exp_w[0] = {16'h0, cur_gs}; exp_w[1] = {16'h0, cur_fs}; exp_w[2] = {16'h0, cur_ds};
    exp_w[3] = {16'h0, cur_es}; exp_w[4] = {16'h0, cur_ss}; exp_w[5] = cur_esp;
    exp_w[6] = fl; exp_w[7] = {16'h0, cur_cs}; exp_w[8] = cur_eip;
    efl = fl & ~32'h0002_0100;
    if (gate_type == 4'hE) efl = efl & ~32'h0000_0200;
    p_cs = out_cs; p_eip = out_eip; p_esp = out_esp; p_fl = out_eflags; p_cpl = out_cpl; p_pm = out_pm32;
    wcnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    ev = -1; seen_ev = 0;
    for (int t = 0; t < 100 && seen_ev == 0; t++) begin
      if (done) ev = 2; else if (task_sw_req) ev = 1; else if (fault) ev = 0;
      if (ev >= 0) begin
        seen_ev = 1;
        if (ev == 1) chk(tsw_vec == vector, "R3 tsw_vec", 64'(tsw_vec), 64'(vector));
        if (ev == 0) chk(fault_vec == 8'd13, "R2 fault_vec", 64'(fault_vec), 64'd13);
      end else begin
        if (t == 2 && kind == 2 && (i % 3) == 0) begin
          gate_type = 4'h0; start = 1;   // R10: start while busy
        end else if (start) begin
          start = 0; gate_type = i[3:0];
        end
        @(negedge clk);
      end
    end
    start = 0;
    chk(ev == kind, (kind == 0) ? "R1 R2 fault event" : (kind == 1) ? "R3 task event" : "R6 R10 done event",
        64'(ev), 64'(kind));
    if (kind != 2) begin
      chk(wcnt == 0, "R2 R3 no writes", 64'(wcnt), 64'd0);
      chk(out_cs == p_cs && out_eip == p_eip && out_esp == p_esp && out_eflags == p_fl &&
          out_cpl == p_cpl && out_pm32 == p_pm, "R9 outputs unchanged", {out_cs, out_eip}, {p_cs, p_eip});
    end else begin
      chk(wcnt == 9, "R4 write count", 64'(wcnt), 64'd9);
      for (int k = 0; k < 9; k++) begin
        chk(r_data[k] == exp_w[k], "R4 R5 R8 push data", 64'(r_data[k]), 64'(exp_w[k]));
        chk(r_addr[k] == stk0_esp - 32'(4 * (k + 1)), "R4 push offset", 64'(r_addr[k]),
            64'(stk0_esp - 32'(4 * (k + 1))));
        chk(r_seg[k] == stk0_ss, "R4 push segment", 64'(r_seg[k]), 64'(stk0_ss));
      end
      chk(out_cs == gate_sel && out_eip == gate_off, "R6 CS:EIP", {out_cs, out_eip}, {gate_sel, gate_off});
      chk(out_ss == stk0_ss && out_esp == stk0_esp - 32'd36, "R6 SS:ESP", {out_ss, out_esp},
          {stk0_ss, stk0_esp - 32'd36});
      chk(out_cpl == 0 && out_pm32 == 1, "R6 cpl/mode", {out_cpl, out_pm32}, 64'd1);
      chk({out_ds, out_es, out_fs, out_gs} == 64'd0, "R7 data segs zero",
          {out_ds, out_es, out_fs, out_gs}, 64'd0);
      chk(out_eflags == efl, "R8 eflags", 64'(out_eflags), 64'(efl));
    end
    @(negedge clk);
    chk(!done && !fault && !task_sw_req, "R1 single pulse", {done, fault, task_sw_req}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fault && !task_sw_req && !mem_wr_valid, "R11 reset events",
        {done, fault, task_sw_req, mem_wr_valid}, 64'd0);
    chk(out_cpl == 2'd3 && out_pm32 == 1'b0, "R11 reset cpl/mode", {out_cpl, out_pm32}, 64'd6);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 128; i++) run_case(i);
    finish_up();
  end
endmodule